// File: doc/BRIEF.md
# Dual-Rail Early-Output Ripple Adder

This block adds two 32-bit operands and a carry-in without any clock. Every logical bit, at the inputs and at the outputs, travels on a pair of wires: a true rail and a false rail. The surrounding logic runs a four-phase return-to-zero cycle. All pairs rest at spacer, then one valid data word is applied, and then the word is withdrawn to spacer again before the next one.

The carry chain starts with two single-bit full-adder cells at the least significant end. Fifteen dual-bit cells follow and cover the upper thirty bits. Each dual-bit cell takes two operand bit pairs and one carry, and produces two sum bits and one carry. The cells follow an early-output discipline. A carry resolves as soon as the inputs already present fix its value, so a position whose two operand bits are equal does not wait for the carry coming from below. The dual-bit cell flattens its carry expression with redundant product terms. This takes the internal middle carry off the path to the cell's carry-out.

A completion detector watches the 32 sum pairs and the carry-out pair. It raises one flag when all 33 pairs hold data and another flag when all 33 pairs are back at spacer. The environment uses these two flags to close each half of the handshake.

Top module: `dr_ripple_adder`

## Requirements
- R1: Each output bit is a pair {true, false}. {1,0} means logic 1, {0,1} means logic 0 and {0,0} means spacer. While the inputs are legal, no output pair ever shows {1,1}.
- R2: When every operand bit and the carry-in hold valid data, the decoded value {cout, sum[31:0]} equals a + b + cin as a 33-bit binary sum.
- R3: When every input pair is spacer, every sum pair and the carry-out pair are {0,0}.
- R4: `done` is high exactly when all 32 sum pairs and the carry-out pair hold valid data.
- R5: `cleared` is high exactly when all 32 sum pairs and the carry-out pair are spacer. `done` and `cleared` are never high together.
- R6: When operand bits 31 of a and b are both valid and equal, the carry-out becomes valid with that value, even if every other input is still spacer.
- R7: When the carry-in is spacer and all operand bits are valid, a sum bit becomes valid only where the carry entering its position is already fixed by equal operand bits below it. Sum bit 0 and every bit that depends on the carry-in stay spacer, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_t | input | 32 | Operand A, true rails |
| a_f | input | 32 | Operand A, false rails |
| b_t | input | 32 | Operand B, true rails |
| b_f | input | 32 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | 32 | Sum, true rails |
| sum_f | output | 32 | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| done | output | 1 | All 33 result pairs hold data |
| cleared | output | 1 | All 33 result pairs are spacer |

## Verification
The bench covers three kinds of case.

The first is full-length carry propagation, for example all ones plus one, or all ones plus all ones with a carry-in. A broken link in the chain, or a dual-bit cell that mixes up its middle carry, gives a wrong upper sum or a wrong carry-out.

The second is partly applied words. With only the top operand bits present, a correct design already shows the carry-out. A design that waits for the whole chain leaves the carry-out at spacer. With the carry-in held back, a correct design resolves only the bits above a position whose operand bits are equal. A design that guesses a carry shows valid bits too early, or raises `done` before the word is complete.

The third is the return to spacer. If any stage holds a value after its inputs have been withdrawn, `cleared` never rises.

// File: rtl/dr_add_pkg.sv
// Package: shared dual-rail types and cell equations.
// Assumes: a pair {t,f} is never driven to {1,1} by the environment.
package dr_add_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } dr_t;

    // Majority carry per rail; resolves early once two agreeing inputs arrive.
    function automatic dr_t dr_carry(input dr_t x, input dr_t y, input dr_t z);
        dr_t r;
        r.t = (x.t & y.t) | (x.t & z.t) | (y.t & z.t);
        r.f = (x.f & y.f) | (x.f & z.f) | (y.f & z.f);
        return r;
    endfunction

    // Three-input parity per rail; needs all three inputs valid.
    function automatic dr_t dr_sum(input dr_t x, input dr_t y, input dr_t z);
        dr_t r;
        r.t = (x.t & y.f & z.f) | (x.f & y.t & z.f) | (x.f & y.f & z.t) | (x.t & y.t & z.t);
        r.f = (x.f & y.f & z.f) | (x.t & y.t & z.f) | (x.t & y.f & z.t) | (x.f & y.t & z.t);
        return r;
    endfunction

endpackage

// File: rtl/dr_fa1.sv
// Module: single-bit dual-rail full adder, early-output carry.
// Assumes: inputs follow the return-to-zero protocol.
module dr_fa1
    import dr_add_pkg::*;
(
    input  dr_t a,
    input  dr_t b,
    input  dr_t ci,
    output dr_t s,
    output dr_t co
);

    // Carry may resolve before ci arrives; sum waits for all inputs.
    assign co = dr_carry(a, b, ci);
    assign s  = dr_sum(a, b, ci);

endmodule

// File: rtl/dr_fa2.sv
// Module: dual-bit dual-rail full adder. The carry-out is a flattened
// sum of products (redundant terms), so it does not pass through the
// internal middle carry.
// Assumes: inputs follow the return-to-zero protocol.
module dr_fa2
    import dr_add_pkg::*;
(
    input  dr_t a0,
    input  dr_t b0,
    input  dr_t a1,
    input  dr_t b1,
    input  dr_t ci,
    output dr_t s0,
    output dr_t s1,
    output dr_t co
);

    dr_t c_mid;

    // Middle carry feeds only the upper sum bit.
    assign c_mid = dr_carry(a0, b0, ci);
    assign s0    = dr_sum(a0, b0, ci);
    assign s1    = dr_sum(a1, b1, c_mid);

    // Flattened true-rail carry: equal upper bits decide it at once.
    assign co.t = (a1.t & b1.t)
                | (a1.t & a0.t & b0.t) | (b1.t & a0.t & b0.t)
                | (a1.t & a0.t & ci.t) | (a1.t & b0.t & ci.t)
                | (b1.t & a0.t & ci.t) | (b1.t & b0.t & ci.t);

    // Flattened false-rail carry, the mirror of the true rail.
    assign co.f = (a1.f & b1.f)
                | (a1.f & a0.f & b0.f) | (b1.f & a0.f & b0.f)
                | (a1.f & a0.f & ci.f) | (a1.f & b0.f & ci.f)
                | (b1.f & a0.f & ci.f) | (b1.f & b0.f & ci.f);

endmodule

// File: rtl/dr_done.sv
// Module: completion detector over W dual-rail pairs.
// Assumes: no pair is {1,1}.
module dr_done #(
    parameter int W = 33
) (
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         all_valid,
    output logic         all_spacer
);

    logic [W-1:0] pair_set;

    // A pair holds data when either rail is high.
    assign pair_set   = rail_t | rail_f;
    assign all_valid  = &pair_set;
    assign all_spacer = ~|pair_set;

endmodule

// File: rtl/dr_ripple_adder.sv
// Module: dual-rail ripple adder. N_SINGLE single-bit cells sit at the
// least significant end and N_DUAL dual-bit cells sit above them. A
// completion detector covers the sum and carry-out pairs.
// Assumes: four-phase return-to-zero operation by the environment. The
// block is purely combinational, so no clock or reset enters it.
module dr_ripple_adder
    import dr_add_pkg::*;
#(
    parameter int N_SINGLE = 2,
    parameter int N_DUAL   = 15,
    localparam int W       = N_SINGLE + 2 * N_DUAL,
    localparam int N_STAGE = N_SINGLE + N_DUAL
) (
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    input  logic [W-1:0] b_t,
    input  logic [W-1:0] b_f,
    input  logic         cin_t,
    input  logic         cin_f,
    output logic [W-1:0] sum_t,
    output logic [W-1:0] sum_f,
    output logic         cout_t,
    output logic         cout_f,
    output logic         done,
    output logic         cleared
);

    dr_t a_d [W];
    dr_t b_d [W];
    dr_t s_d [W];
    dr_t cy  [N_STAGE+1];

    // Pack the operand rails into pairs and unpack the sum rails.
    for (genvar i = 0; i < W; i++) begin : g_pack
        assign a_d[i]   = '{t: a_t[i], f: a_f[i]};
        assign b_d[i]   = '{t: b_t[i], f: b_f[i]};
        assign sum_t[i] = s_d[i].t;
        assign sum_f[i] = s_d[i].f;
    end

    // Chain ends: carry-in enters stage 0, and the last carry leaves as cout.
    assign cy[0]  = '{t: cin_t, f: cin_f};
    assign cout_t = cy[N_STAGE].t;
    assign cout_f = cy[N_STAGE].f;

    // Single-bit cells at the least significant positions.
    for (genvar i = 0; i < N_SINGLE; i++) begin : g_single
        dr_fa1 u_fa1 (
            .a  (a_d[i]),
            .b  (b_d[i]),
            .ci (cy[i]),
            .s  (s_d[i]),
            .co (cy[i+1])
        );
    end

    // Dual-bit cells over the remaining positions.
    for (genvar j = 0; j < N_DUAL; j++) begin : g_dual
        localparam int LO = N_SINGLE + 2 * j;
        localparam int ST = N_SINGLE + j;
        dr_fa2 u_fa2 (
            .a0 (a_d[LO]),
            .b0 (b_d[LO]),
            .a1 (a_d[LO+1]),
            .b1 (b_d[LO+1]),
            .ci (cy[ST]),
            .s0 (s_d[LO]),
            .s1 (s_d[LO+1]),
            .co (cy[ST+1])
        );
    end

    // Completion over every sum pair plus the carry-out pair.
    dr_done #(.W(W + 1)) u_done (
        .rail_t     ({cout_t, sum_t}),
        .rail_f     ({cout_f, sum_f}),
        .all_valid  (done),
        .all_spacer (cleared)
    );

endmodule

// File: rtl/dr_ripple_adder_chk.sv
// Module: checker for dr_ripple_adder, attached by bind. It holds only
// immediate checks, because the block has no clock.
module dr_ripple_adder_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_t,
    input logic [W-1:0] a_f,
    input logic [W-1:0] b_t,
    input logic [W-1:0] b_f,
    input logic         cin_t,
    input logic         cin_f,
    input logic [W-1:0] sum_t,
    input logic [W-1:0] sum_f,
    input logic         cout_t,
    input logic         cout_f,
    input logic         done,
    input logic         cleared
);

    logic in_valid;
    logic in_spacer;
    logic [W:0] ref_sum;

    // Classify the input word and form the reference sum.
    assign in_valid  = (&(a_t | a_f)) & (&(b_t | b_f)) & (cin_t | cin_f);
    assign in_spacer = ~|{a_t, a_f, b_t, b_f, cin_t, cin_f};
    assign ref_sum   = {1'b0, a_t} + {1'b0, b_t} + {{W{1'b0}}, cin_t};

    // Check outputs against the inputs after the network settles.
    always_comb begin
        assert_no_illegal_R1: assert (((sum_t & sum_f) == '0) && !(cout_t & cout_f))
            else $error("R1: illegal output pair");
        assert_flags_exclusive_R5: assert (!(done && cleared))
            else $error("R5: done and cleared together");
        if (in_spacer) begin
            assert_return_zero_R3: assert (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f && cleared)
                else $error("R3: outputs not spacer");
        end
        if (in_valid) begin
            assert_sum_value_R2: assert ({cout_t, sum_t} == ref_sum && {cout_f, sum_f} == ~ref_sum)
                else $error("R2: wrong sum");
            assert_done_R4: assert (done)
                else $error("R4: done low on full word");
        end
        if ((a_t[W-1] & b_t[W-1]) | (a_f[W-1] & b_f[W-1])) begin
            assert_early_carry_R6: assert (cout_t == a_t[W-1] && cout_f == a_f[W-1])
                else $error("R6: carry-out not early");
        end
    end

endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.W(W)) u_chk (
    .a_t     (a_t),
    .a_f     (a_f),
    .b_t     (b_t),
    .b_f     (b_f),
    .cin_t   (cin_t),
    .cin_f   (cin_f),
    .sum_t   (sum_t),
    .sum_f   (sum_f),
    .cout_t  (cout_t),
    .cout_f  (cout_f),
    .done    (done),
    .cleared (cleared)
);

// File: tb/dr_ripple_adder_test.sv
// Bench: walks a vector table with spacer phases in between, then random
// words, then directed partial-word cases.
module dr_ripple_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic        cin_t = 1'b0, cin_f = 1'b0;
    logic [31:0] sum_t, sum_f;
    logic        cout_t, cout_f, done, cleared;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    // Entries are {cin, a, b}.
    localparam logic [64:0] VEC [12] = '{
        {1'b0, 32'h00000000, 32'h00000000},
        {1'b1, 32'h00000000, 32'h00000000},
        {1'b0, 32'hFFFFFFFF, 32'h00000001},
        {1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {1'b0, 32'h80000000, 32'h80000000},
        {1'b1, 32'hAAAAAAAA, 32'h55555555},
        {1'b0, 32'h12345678, 32'h9ABCDEF0},
        {1'b1, 32'h7FFFFFFF, 32'h00000000},
        {1'b0, 32'h0000FFFF, 32'h00010000},
        {1'b1, 32'hDEADBEEF, 32'h21524110},
        {1'b0, 32'h00000003, 32'h00000001},
        {1'b1, 32'hFFFF0000, 32'h0000FFFF}
    };

    dr_ripple_adder uut (
        .a_t (a_t), .a_f (a_f), .b_t (b_t), .b_f (b_f),
        .cin_t (cin_t), .cin_f (cin_f),
        .sum_t (sum_t), .sum_f (sum_f),
        .cout_t (cout_t), .cout_f (cout_f),
        .done (done), .cleared (cleared)
    );

    // 200 MHz clock, used to pace the phases.
    always #2.5 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a full valid word at a rising edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(posedge clk);
        a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
    endtask

    // Withdraw to spacer and check the return to zero.
    task automatic spacer_phase();
        @(posedge clk);
        a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
        @(negedge clk);
        check("R3", {sum_t, sum_f}, 64'h0);
        check("R3", {62'h0, cout_t, cout_f}, 64'h0);
        check("R5", {62'h0, cleared, done}, 64'h2);
    endtask

    // Apply a word and check value, encoding and flags.
    task automatic data_phase(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] exp;
        exp = {1'b0, a} + {1'b0, b} + {32'h0, c};
        apply(a, b, c);
        @(negedge clk);
        check("R1", {32'h0, sum_t & sum_f}, 64'h0);
        check("R2", {31'h0, cout_t, sum_t}, {31'h0, exp});
        check("R2", {31'h0, cout_f, sum_f}, {31'h0, ~exp});
        check("R4", {62'h0, done, cleared}, 64'h2);
    endtask

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: inputs at spacer, nothing resolved.
        check("R5", {62'h0, cleared, done}, 64'h2);
        check("R3", {sum_t, sum_f}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            data_phase(VEC[i][63:32], VEC[i][31:0], VEC[i][64]);
            spacer_phase();
        end

        for (int i = 0; i < 40; i++) begin
            data_phase($urandom, $urandom, 1'($urandom));
            spacer_phase();
        end

        // R6: only the top bits present, both one.
        @(posedge clk);
        a_t = 32'h80000000; b_t = 32'h80000000;
        @(negedge clk);
        check("R6", {62'h0, cout_t, cout_f}, 64'h2);
        check("R4", {62'h0, done, cleared}, 64'h0);
        check("R6", {62'h0, sum_t[31], sum_f[31]}, 64'h0);
        spacer_phase();

        // R6: only the top bits present, both zero.
        @(posedge clk);
        a_f = 32'h80000000; b_f = 32'h80000000;
        @(negedge clk);
        check("R6", {62'h0, cout_t, cout_f}, 64'h1);
        spacer_phase();

        // R7: carry-in held back, bit 0 generates, so bits 31..1 resolve.
        @(posedge clk);
        a_t = 32'h1; a_f = ~32'h1; b_t = 32'h1; b_f = ~32'h1;
        @(negedge clk);
        check("R7", {sum_t, sum_f}, {32'h2, 32'hFFFFFFFC});
        check("R7", {61'h0, cout_t, cout_f, done}, 64'h2);
        spacer_phase();

        // R7: carry-in held back, bit 0 propagates, so bits 1 and 0 stay spacer.
        @(posedge clk);
        a_t = 32'h1; a_f = ~32'h1; b_t = 32'h0; b_f = 32'hFFFFFFFF;
        @(negedge clk);
        check("R7", {sum_t, sum_f}, {32'h0, 32'hFFFFFFFC});
        check("R7", {61'h0, cout_t, cout_f, done}, 64'h2);
        // Releasing the carry-in completes the word.
        @(posedge clk);
        cin_f = 1'b1;
        @(negedge clk);
        check("R4", {62'h0, done, cleared}, 64'h2);
        check("R2", {31'h0, cout_t, sum_t}, 64'h1);
        spacer_phase();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule